// File: doc/BRIEF.md
# Index and Sector Pulse Generator

This block sits between the servo clock-track recovery logic of a fixed-disk drive and its host interface. It receives two single-cycle strobes in the system clock domain. One marks every recovered byte period. The other marks the physical index, once per revolution. From these it builds the index pulse and the sector mark pulses that the host controller sees. The track is divided into sectors by a 12-bit bytes-per-sector word. A sector mark fires each time that many bytes have passed since the start of the current sector. The counting restarts at every index.

When the track length is not an exact multiple of the sector length, the final sector takes the leftover bytes. The generator therefore never starts a sector that would not fit in full before index. Two static option bits shape the output:

- The first switches the shared output line from sector marks to a stretched copy of the byte clock.
- The second adds a sector mark at the index moment.

A sector-number register restarts at 0 on index and advances on each mark. All pulse widths are counted in system-clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `idxsec_pulse_gen`

## Requirements
- R1: After reset, `index_pulse` and `sect_pulse` are 0 and `sector_num` is 0.
- R2: An `index_stb` sampled at a clock edge drives `index_pulse` high from that edge for exactly ceil(1.7 × CLKS_PER_US) cycles. A further `index_stb` while the pulse is high restarts the full width from the new edge.
- R3: With `out_sel_byteclk` = 0 and `bps_cfg` = N ≠ 0, a sector mark is issued at the byte strobe that completes byte N of the current sector, counting from index. It appears as `sect_pulse` going high from the edge that samples that strobe. No mark is issued at any other byte strobe.
- R4: A mark at byte position p after index (p counted from 1) is issued only if p + N ≤ TRACK_BYTES. When the room check fails, no mark is issued and the final sector keeps counting up to index, so it is N plus the remainder bytes long.
- R5: `sector_num` becomes 0 at the edge that samples `index_stb` and increases by exactly 1 at each sector mark issued by a byte strobe. It changes at no other time.
- R6: A sector mark holds `sect_pulse` high (in mark mode) for ceil(1.7 × CLKS_PER_US) cycles, restarting on a new mark.
- R7: With `out_sel_byteclk` = 1, every byte strobe drives `sect_pulse` high for ceil(0.84 × CLKS_PER_US) cycles, and sector marks are not shown on `sect_pulse`. `sector_num` still counts marks.
- R8: With `mark_on_index` = 1 and `bps_cfg` ≠ 0, a sector mark is also issued at the edge that samples `index_stb`, and `sector_num` reads 0 after it. With `mark_on_index` = 0, no mark accompanies index.
- R9: With `bps_cfg` = 0, no sector mark is ever issued, even when `mark_on_index` = 1. `sector_num` stays 0 and only `index_pulse` is produced.
- R10: When `index_stb` and `byte_stb` are sampled at the same edge, index takes effect and that byte is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One-cycle strobe per recovered byte period |
| index_stb | input | 1 | One-cycle strobe at the physical index |
| bps_cfg | input | CFG_W | Bytes per sector, binary; 0 disables sector marks |
| out_sel_byteclk | input | 1 | 0: `sect_pulse` carries sector marks; 1: carries the byte clock |
| mark_on_index | input | 1 | 1: also issue a sector mark at index |
| index_pulse | output | 1 | Stretched index pulse |
| sect_pulse | output | 1 | Stretched sector mark or byte-clock pulse, per `out_sel_byteclk` |
| sector_num | output | SEC_W | Current sector number, 0 after index |

## Verification
A wrong byte position or sector-run count shows up at the very next byte strobe that should, or should not, raise a mark. A missing mark near the end of the track shows up only on the last sector, so the bench sweeps every sector length from 0 to beyond the track length on a short track. A sector number that fails to clear or that skips is visible one cycle after the index or mark that should have set it. Pulse-width counter faults are caught by sampling the cycle just before and just after each expected falling edge, including after a retrigger.

// File: rtl/idxsec_pkg.sv
package idxsec_pkg;

   // cycles needed to cover num/den microseconds, rounded up
   function automatic int unsigned span_cycles(input int unsigned per_us,
                                               input int unsigned num,
                                               input int unsigned den);
      return (per_us * num + den - 1) / den;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // tenths / hundredths of a microsecond for each output pulse
   localparam int unsigned IDX_NUM  = 17;
   localparam int unsigned IDX_DEN  = 10;
   localparam int unsigned BYTE_NUM = 84;
   localparam int unsigned BYTE_DEN = 100;

endpackage

// File: rtl/idxsec_stretch.sv
module idxsec_stretch #(
   parameter int unsigned WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int unsigned CW = (WIDTH < 2) ? 1 : $clog2(WIDTH + 1);

   generate
      if (WIDTH == 0) begin : g_bad
         $error("idxsec_stretch: WIDTH must be at least 1");
      end
      if (WIDTH == 1) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n) active <= 1'b0;
            else        active <= trig;
         end
      end else begin : g_count
         logic [CW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              left_q <= '0;
            else if (trig)           left_q <= CW'(WIDTH);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign active = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/idxsec_byte_tracker.sv
module idxsec_byte_tracker #(
   parameter int unsigned TRACK_BYTES = 12000,
   parameter int unsigned CFG_W       = 12,
   parameter int unsigned POS_W       = 14,
   parameter int unsigned SEC_W       = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic             index_stb,
   input  logic [CFG_W-1:0] bps,
   input  logic             mark_on_index,
   output logic             mark_stb,
   output logic [SEC_W-1:0] sector_num
);
   localparam int unsigned CMP_W = idxsec_pkg::max2(POS_W, CFG_W) + 2;

   logic [POS_W-1:0] pos_q;
   logic [CMP_W-1:0] run_q;
   logic [SEC_W-1:0] sec_q;
   logic [CMP_W-1:0] pos_nx, run_nx, bps_x;
   logic             enabled, hit, room, byte_mark;

   always_comb begin
      bps_x     = CMP_W'(bps);
      pos_nx    = CMP_W'(pos_q) + 1'b1;
      run_nx    = run_q + 1'b1;
      enabled   = (bps != '0);
      hit       = enabled && (run_nx == bps_x);
      room      = (pos_nx + bps_x) <= CMP_W'(TRACK_BYTES);
      byte_mark = byte_stb && hit && room;
      if (index_stb) mark_stb = mark_on_index && enabled;
      else           mark_stb = byte_mark;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         run_q <= '0;
         sec_q <= '0;
      end else if (index_stb) begin
         pos_q <= '0;
         run_q <= '0;
         sec_q <= '0;
      end else if (byte_stb) begin
         if (pos_q != '1) pos_q <= pos_q + 1'b1;
         if (byte_mark) begin
            run_q <= '0;
            sec_q <= sec_q + 1'b1;
         end else if (run_q != '1) begin
            run_q <= run_nx;
         end
      end
   end

   assign sector_num = sec_q;
endmodule

// File: rtl/idxsec_pulse_gen.sv
module idxsec_pulse_gen #(
   parameter int unsigned TRACK_BYTES = 12000,
   parameter int unsigned CFG_W       = 12,
   parameter int unsigned CLKS_PER_US = 100,
   localparam int unsigned SEC_W      = $clog2(TRACK_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic             index_stb,
   input  logic [CFG_W-1:0] bps_cfg,
   input  logic             out_sel_byteclk,
   input  logic             mark_on_index,
   output logic             index_pulse,
   output logic             sect_pulse,
   output logic [SEC_W-1:0] sector_num
);
   import idxsec_pkg::*;

   localparam int unsigned POS_W  = SEC_W;
   localparam int unsigned IDX_W  = span_cycles(CLKS_PER_US, IDX_NUM, IDX_DEN);
   localparam int unsigned BYTE_W = span_cycles(CLKS_PER_US, BYTE_NUM, BYTE_DEN);

   generate
      if (TRACK_BYTES < 2) begin : g_bad_track
         $error("idxsec_pulse_gen: TRACK_BYTES must be at least 2");
      end
      if (CFG_W < 1 || CFG_W > 16) begin : g_bad_cfg
         $error("idxsec_pulse_gen: CFG_W must be 1..16");
      end
      if (CLKS_PER_US < 1) begin : g_bad_clk
         $error("idxsec_pulse_gen: CLKS_PER_US must be at least 1");
      end
   endgenerate

   logic mark_stb, idx_act, mark_act, byte_act;

   idxsec_byte_tracker #(
      .TRACK_BYTES (TRACK_BYTES),
      .CFG_W       (CFG_W),
      .POS_W       (POS_W),
      .SEC_W       (SEC_W)
   ) u_track (
      .clk           (clk),
      .rst_n         (rst_n),
      .byte_stb      (byte_stb),
      .index_stb     (index_stb),
      .bps           (bps_cfg),
      .mark_on_index (mark_on_index),
      .mark_stb      (mark_stb),
      .sector_num    (sector_num)
   );

   idxsec_stretch #(.WIDTH(IDX_W)) u_idx (
      .clk (clk), .rst_n (rst_n), .trig (index_stb), .active (idx_act)
   );

   idxsec_stretch #(.WIDTH(IDX_W)) u_mark (
      .clk (clk), .rst_n (rst_n), .trig (mark_stb), .active (mark_act)
   );

   idxsec_stretch #(.WIDTH(BYTE_W)) u_byte (
      .clk (clk), .rst_n (rst_n), .trig (byte_stb), .active (byte_act)
   );

   assign index_pulse = idx_act;
   assign sect_pulse  = out_sel_byteclk ? byte_act : mark_act;
endmodule

// File: rtl/idxsec_pulse_chk.sv
module idxsec_pulse_chk #(
   parameter int unsigned TRACK_BYTES = 12000,
   parameter int unsigned CFG_W       = 12,
   localparam int unsigned SEC_W      = $clog2(TRACK_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_stb,
   input logic             index_stb,
   input logic [CFG_W-1:0] bps_cfg,
   input logic             out_sel_byteclk,
   input logic             mark_on_index,
   input logic             index_pulse,
   input logic             sect_pulse,
   input logic [SEC_W-1:0] sector_num
);
   AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(index_stb) |-> index_pulse);                                   // R2

   AST_SEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(index_stb) |-> (sector_num == '0));                            // R5

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(index_stb) && (sector_num != $past(sector_num)))
      |-> (sector_num == $past(sector_num) + 1'b1));                       // R5

   AST_NO_SPURIOUS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sect_pulse) && !out_sel_byteclk && !$past(out_sel_byteclk))
      |-> ($past(index_stb) || $past(byte_stb)));                          // R3

   AST_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel_byteclk && $past(out_sel_byteclk) && $past(byte_stb))
      |-> sect_pulse);                                                     // R7

   AST_MARK_AT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(index_stb) && $past(mark_on_index) && ($past(bps_cfg) != '0)
       && !out_sel_byteclk && !$past(out_sel_byteclk)) |-> sect_pulse);   // R8

   AST_ZERO_BPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((bps_cfg == '0) && ($past(bps_cfg) == '0) && ($past(sector_num) == '0))
      |-> (sector_num == '0));                                             // R9
endmodule

bind idxsec_pulse_gen idxsec_pulse_chk #(
   .TRACK_BYTES (TRACK_BYTES),
   .CFG_W       (CFG_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .byte_stb        (byte_stb),
   .index_stb       (index_stb),
   .bps_cfg         (bps_cfg),
   .out_sel_byteclk (out_sel_byteclk),
   .mark_on_index   (mark_on_index),
   .index_pulse     (index_pulse),
   .sect_pulse      (sect_pulse),
   .sector_num      (sector_num)
);

// File: tb/sim_idxsec_pulse_gen.sv
module sim_idxsec_pulse_gen;
   localparam int TRACK  = 40;
   localparam int CFG_W  = 12;
   localparam int PER_US = 10;
   localparam int IDX_W  = (PER_US * 17 + 9) / 10;    // 17
   localparam int BYTE_W = (PER_US * 84 + 99) / 100;  // 9
   localparam int GAP    = 20;                        // cycles between strobes
   localparam int SEC_W  = $clog2(TRACK + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic byte_stb = 1'b0;
   logic index_stb = 1'b0;
   logic [CFG_W-1:0] bps_cfg = '0;
   logic out_sel_byteclk = 1'b0;
   logic mark_on_index = 1'b0;
   logic index_pulse, sect_pulse;
   logic [SEC_W-1:0] sector_num;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   idxsec_pulse_gen #(
      .TRACK_BYTES (TRACK),
      .CFG_W       (CFG_W),
      .CLKS_PER_US (PER_US)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .byte_stb (byte_stb), .index_stb (index_stb),
      .bps_cfg (bps_cfg), .out_sel_byteclk (out_sel_byteclk),
      .mark_on_index (mark_on_index), .index_pulse (index_pulse),
      .sect_pulse (sect_pulse), .sector_num (sector_num)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // strobe sampled at the next posedge; returns at the negedge after it
   task automatic pulse_in(input bit idx, input bit byt);
      @(negedge clk);
      index_stb = idx;
      byte_stb  = byt;
      @(negedge clk);
      index_stb = 1'b0;
      byte_stb  = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1 reset state
      check("R1 index_pulse", index_pulse, 0);
      check("R1 sect_pulse", sect_pulse, 0);
      check("R1 sector_num", sector_num, 0);
      rst_n = 1'b1;
      idle(2);

      // R2 index width and retrigger
      pulse_in(1, 0);
      check("R2 index high at start", index_pulse, 1);
      idle(IDX_W - 1);
      check("R2 index high last cycle", index_pulse, 1);
      idle(1);
      check("R2 index low after width", index_pulse, 0);
      pulse_in(1, 0);
      idle(4);
      pulse_in(1, 0);
      idle(IDX_W - 1);
      check("R2 retrigger high", index_pulse, 1);
      idle(1);
      check("R2 retrigger low", index_pulse, 0);

      // R3 R4 R5 R8 R9 sweep of all sector lengths
      for (int n = 0; n <= TRACK + 2; n++) begin
         int sec;
         @(negedge clk);
         bps_cfg = CFG_W'(n);
         out_sel_byteclk = 1'b0;
         mark_on_index = n[0];
         pulse_in(1, 0);
         check("R5 sector_num at index", sector_num, 0);
         if (n == 0) check("R9 no mark at index", sect_pulse, 0);
         else        check("R8 mark with index", sect_pulse, n[0] ? 1 : 0);
         idle(GAP - 2);
         sec = 0;
         for (int p = 1; p <= TRACK; p++) begin
            bit exp;
            exp = (n != 0) && (p % n == 0) && (p + n <= TRACK);
            pulse_in(0, 1);
            if (exp) sec++;
            if (n == 0)
               check("R9 no mark", sect_pulse, 0);
            else if (p % n == 0 && !exp)
               check("R4 last sector absorbs remainder", sect_pulse, 0);
            else
               check("R3 mark position", sect_pulse, exp ? 1 : 0);
            check("R5 sector_num", sector_num, sec);
            idle(GAP - 2);
         end
      end

      // R6 mark width
      @(negedge clk);
      bps_cfg = 1; mark_on_index = 0;
      pulse_in(1, 0);
      idle(GAP);
      pulse_in(0, 1);
      check("R6 mark high at start", sect_pulse, 1);
      idle(IDX_W - 1);
      check("R6 mark high last cycle", sect_pulse, 1);
      idle(1);
      check("R6 mark low after width", sect_pulse, 0);

      // R7 byte-clock mode
      @(negedge clk);
      bps_cfg = 3; out_sel_byteclk = 1'b1;
      pulse_in(1, 0);
      check("R7 no mark shown at index", sect_pulse, 0);
      idle(GAP);
      for (int p = 1; p <= 6; p++) begin
         pulse_in(0, 1);
         check("R7 byte pulse", sect_pulse, 1);
         check("R7 sector_num counts", sector_num, p / 3);
         idle(BYTE_W - 1);
         check("R7 byte pulse last cycle", sect_pulse, 1);
         idle(1);
         check("R7 byte pulse ends", sect_pulse, 0);
         idle(GAP - BYTE_W - 2);
      end

      // R10 index dominates coincident byte
      @(negedge clk);
      bps_cfg = 2; out_sel_byteclk = 1'b0;
      pulse_in(1, 0);
      idle(GAP);
      pulse_in(0, 1);
      pulse_in(0, 1);
      check("R10 setup sector_num", sector_num, 1);
      idle(GAP);
      pulse_in(1, 1);
      check("R10 sector_num cleared", sector_num, 0);
      idle(GAP);
      pulse_in(0, 1);
      check("R10 first byte no mark", sect_pulse, 0);
      idle(GAP);
      pulse_in(0, 1);
      check("R10 mark at second byte", sect_pulse, 1);
      check("R10 sector_num", sector_num, 1);

      idle(GAP);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule